// File: doc/BRIEF.md
# RTC Shadow Register Access Controller

This block sits between a processor's simple byte-wide register bus and a free-running real-time counter. It keeps a byte-addressable shadow copy of the counter value and of the two rate-trim words (a 17-bit fine word and a 2-bit coarse word). Software never touches the live counter directly. It reads and writes the shadow, and the block decides when the shadow follows the counter and when the shadow is copied back into it.

Two control bits steer the shadow. A read-freeze bit stops the shadow from tracking, so a multi-byte read returns one coherent time. A write-hold bit also stops tracking and opens the shadow fields for writing. When software clears the write-hold bit, the block waits for the next pulse of the slow RTC enable (about 1 kHz). On that pulse it issues a one-cycle commit strobe that carries the shadow counter and trim values. The write-hold bit keeps reading 1 until that commit has happened. A sticky fault flag latches any count error that the counter reports, and only a software write of 0 clears it.

Top module: `rtc_shadow_ctrl`

## Requirements
- R1: After a synchronous reset, every output is 0. Every address also reads back 0, including the shadow bytes and the control byte.
- R2: Writing a control byte with bit 6 = 1 freezes the shadow, so RTC enable pulses no longer reload it. Writing bit 6 = 0 lets the next enable pulse reload it again.
- R3: The control byte at address 0 reads as follows. Bit 7 is the write-hold status, bit 6 is the read-freeze bit and bit 4 is the fault flag. All other bits read 0. The same three values also appear on `wr_busy_o`, `rd_frozen_o` and `fault_o`.
- R4: The shadow reloads from `live_cnt`, `live_p` and `live_q` on every `rtc_tick` pulse, but only while read-freeze, write-hold and a pending commit are all inactive. Between pulses the shadow keeps its value.
- R5: While write-hold is set, the shadow ignores `rtc_tick` and accepts byte writes. The counter occupies addresses 1 to 4, least significant byte first. The fine trim occupies addresses 5 to 7, least significant byte first, and only bit 0 of address 7 is kept. The coarse trim is at address 8, bits 1:0. Bits that are not stored read 0.
- R6: A write to addresses 1 to 8 while write-hold is 0 leaves the shadow unchanged.
- R7: Writing bit 7 = 0 while write-hold is 1 makes a commit pending. The commit fires on the first `rtc_tick` at which write-hold is 0. `commit_o` then rises in the following cycle, with `commit_cnt_o`, `commit_p_o` and `commit_q_o` equal to the shadow contents. If write-hold is set again before that tick, the commit waits.
- R8: Bit 7 of the control byte reads 1 while write-hold is set or a commit is pending. It drops in the same cycle that `commit_o` rises.
- R9: `fault_o` is set one cycle after a `cnt_err` pulse and stays set. A control write with bit 4 = 0 clears it, and a write with bit 4 = 1 has no effect. If `cnt_err` arrives in the same cycle as a clearing write, the flag stays set.
- R10: `commit_o` is high for exactly one cycle per commit. It never rises without a pending commit.
- R11: `rdata` is registered. It shows the addressed byte in the cycle after `rd_en` and holds its value otherwise. Addresses 9 to 15 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Bus write strobe |
| rd_en | input | 1 | Bus read strobe |
| addr | input | ADDR_W | Bus byte address |
| wdata | input | 8 | Bus write data |
| rdata | output | 8 | Registered bus read data |
| live_cnt | input | CNT_W | Live counter value |
| live_p | input | P_W | Live fine rate-trim word |
| live_q | input | Q_W | Live coarse rate-trim word |
| rtc_tick | input | 1 | Slow RTC enable, one system cycle wide |
| cnt_err | input | 1 | Count-error pulse from the counter |
| commit_o | output | 1 | One-cycle strobe that loads the counter |
| commit_cnt_o | output | CNT_W | Counter value to load |
| commit_p_o | output | P_W | Fine trim value to load |
| commit_q_o | output | Q_W | Coarse trim value to load |
| rd_frozen_o | output | 1 | Read-freeze bit |
| wr_busy_o | output | 1 | Write-hold status (hold set or commit pending) |
| fault_o | output | 1 | Sticky count-fault flag |

## Verification
The assertions check the following on every cycle:
- the commit strobe is a single pulse, and it follows only an enable pulse taken while busy;
- the busy status falls only together with a commit;
- the committed counter equals the shadow of the previous cycle;
- the shadow stays stable when it is frozen, between enable pulses, and while write-hold is clear without a tick;
- the fault flag is sticky, and only a clearing write releases it.

Only the bench scenarios show the rest:
- the byte layout of the shadow, including the masking of the partial trim bytes;
- the exact values carried by a commit after byte writes;
- the deferral of a commit when write-hold is set again before the tick;
- the full set of control-byte transitions, swept over all 256 write values.

// File: rtl/rtc_shadow_pkg.sv
package rtc_shadow_pkg;
  localparam int BYTE_W         = 8;
  localparam int CTRL_HOLD_BIT  = 7;
  localparam int CTRL_FRZ_BIT   = 6;
  localparam int CTRL_FAULT_BIT = 4;

  // number of bus bytes needed to hold a field of w bits
  function automatic int bytes_for(input int w);
    return (w + BYTE_W - 1) / BYTE_W;
  endfunction

  // bits of one lane that fall inside a field of the given width
  function automatic logic [BYTE_W-1:0] lane_mask(input int bit_lo, input int width);
    logic [BYTE_W-1:0] m;
    for (int b = 0; b < BYTE_W; b++) m[b] = ((bit_lo + b) < width);
    return m;
  endfunction
endpackage

// File: rtl/rtc_shadow_ctl.sv
module rtc_shadow_ctl (
  input  logic clk,
  input  logic rst,
  input  logic ctrl_wr,
  input  logic wr_hold_bit,
  input  logic wr_frz_bit,
  input  logic wr_fault_bit,
  input  logic rtc_tick,
  input  logic cnt_err,
  output logic hold_o,
  output logic frz_o,
  output logic busy_o,
  output logic fault_o,
  output logic fire_o,
  output logic load_o
);
  logic hold_q, frz_q, pend_q, fault_q, busy_q;
  logic hold_n, frz_n, pend_n, fault_n;

  // commit fires on a tick once hold has been released
  assign fire_o = pend_q && rtc_tick && !hold_q;
  // tracking reload only when nothing freezes the shadow
  assign load_o = rtc_tick && !frz_q && !hold_q && !pend_q;

  always_comb begin
    hold_n  = hold_q;
    frz_n   = frz_q;
    pend_n  = pend_q;
    fault_n = fault_q;
    if (fire_o) pend_n = 1'b0;
    if (ctrl_wr) begin
      hold_n = wr_hold_bit;
      frz_n  = wr_frz_bit;
      if (hold_q && !wr_hold_bit) pend_n = 1'b1;
      if (!wr_fault_bit) fault_n = 1'b0;
    end
    if (cnt_err) fault_n = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q  <= 1'b0;
      frz_q   <= 1'b0;
      pend_q  <= 1'b0;
      fault_q <= 1'b0;
      busy_q  <= 1'b0;
    end else begin
      hold_q  <= hold_n;
      frz_q   <= frz_n;
      pend_q  <= pend_n;
      fault_q <= fault_n;
      busy_q  <= hold_n | pend_n;
    end
  end

  assign hold_o  = hold_q;
  assign frz_o   = frz_q;
  assign busy_o  = busy_q;
  assign fault_o = fault_q;
endmodule

// File: rtl/rtc_shadow_store.sv
module rtc_shadow_store
  import rtc_shadow_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int P_W    = 17,
  parameter int Q_W    = 2,
  parameter int ADDR_W = 4,
  localparam int CNT_B  = bytes_for(CNT_W),
  localparam int P_B    = bytes_for(P_W),
  localparam int Q_B    = bytes_for(Q_W),
  localparam int NBYTES = CNT_B + P_B + Q_B,
  localparam int FV_W   = NBYTES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_en,
  input  logic              hold,
  input  logic              field_wr,
  input  logic [ADDR_W-1:0] field_idx,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [CNT_W-1:0]  live_cnt,
  input  logic [P_W-1:0]    live_p,
  input  logic [Q_W-1:0]    live_q,
  output logic [FV_W-1:0]   shadow_vec
);
  localparam int P_OFF = CNT_B * BYTE_W;
  localparam int Q_OFF = (CNT_B + P_B) * BYTE_W;

  logic [FV_W-1:0] live_vec;

  always_comb begin
    live_vec = '0;
    live_vec[0 +: CNT_W]   = live_cnt;
    live_vec[P_OFF +: P_W] = live_p;
    live_vec[Q_OFF +: Q_W] = live_q;
  end

  for (genvar i = 0; i < NBYTES; i++) begin : g_lane
    localparam int BASE = (i < CNT_B) ? 0 : ((i < CNT_B + P_B) ? CNT_B : CNT_B + P_B);
    localparam int FW   = (i < CNT_B) ? CNT_W : ((i < CNT_B + P_B) ? P_W : Q_W);
    localparam logic [BYTE_W-1:0] MSK = lane_mask((i - BASE) * BYTE_W, FW);
    logic [BYTE_W-1:0] lane_q;
    logic              sel;

    assign sel = field_wr && hold && (field_idx == ADDR_W'(i));

    always_ff @(posedge clk) begin
      if (rst)          lane_q <= '0;
      else if (load_en) lane_q <= live_vec[i*BYTE_W +: BYTE_W] & MSK;
      else if (sel)     lane_q <= wdata & MSK;
    end

    assign shadow_vec[i*BYTE_W +: BYTE_W] = lane_q;
  end
endmodule

// File: rtl/rtc_shadow_rdmux.sv
module rtc_shadow_rdmux
  import rtc_shadow_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int NBYTES = 8,
  localparam int FV_W  = NBYTES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] ctrl_byte,
  input  logic [FV_W-1:0]   shadow_vec,
  output logic [BYTE_W-1:0] rdata
);
  logic [BYTE_W-1:0] sel_byte;
  logic [BYTE_W-1:0] rdata_q;

  always_comb begin
    sel_byte = '0;
    if (addr == '0) sel_byte = ctrl_byte;
    for (int i = 0; i < NBYTES; i++) begin
      if (addr == ADDR_W'(i + 1)) sel_byte = shadow_vec[i*BYTE_W +: BYTE_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata_q <= '0;
    else if (rd_en) rdata_q <= sel_byte;
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/rtc_shadow_ctrl.sv
module rtc_shadow_ctrl
  import rtc_shadow_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int P_W    = 17,
  parameter int Q_W    = 2,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  logic [CNT_W-1:0]  live_cnt,
  input  logic [P_W-1:0]    live_p,
  input  logic [Q_W-1:0]    live_q,
  input  logic              rtc_tick,
  input  logic              cnt_err,
  output logic              commit_o,
  output logic [CNT_W-1:0]  commit_cnt_o,
  output logic [P_W-1:0]    commit_p_o,
  output logic [Q_W-1:0]    commit_q_o,
  output logic              rd_frozen_o,
  output logic              wr_busy_o,
  output logic              fault_o
);
  localparam int CNT_B  = bytes_for(CNT_W);
  localparam int P_B    = bytes_for(P_W);
  localparam int NBYTES = CNT_B + P_B + bytes_for(Q_W);
  localparam int FV_W   = NBYTES * BYTE_W;
  localparam int P_OFF  = CNT_B * BYTE_W;
  localparam int Q_OFF  = (CNT_B + P_B) * BYTE_W;
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(NBYTES);

  logic              ctrl_wr, field_wr;
  logic [ADDR_W-1:0] field_idx;
  logic              hold_w, frz_w, busy_w, fault_w, fire_w, load_w;
  logic [FV_W-1:0]   shadow_vec;
  logic [7:0]        ctrl_byte;

  assign ctrl_wr   = wr_en && (addr == '0);
  assign field_wr  = wr_en && (addr != '0) && (addr <= LAST_ADDR);
  assign field_idx = addr - ADDR_W'(1);

  rtc_shadow_ctl ctl_i (
    .clk          (clk),
    .rst          (rst),
    .ctrl_wr      (ctrl_wr),
    .wr_hold_bit  (wdata[CTRL_HOLD_BIT]),
    .wr_frz_bit   (wdata[CTRL_FRZ_BIT]),
    .wr_fault_bit (wdata[CTRL_FAULT_BIT]),
    .rtc_tick     (rtc_tick),
    .cnt_err      (cnt_err),
    .hold_o       (hold_w),
    .frz_o        (frz_w),
    .busy_o       (busy_w),
    .fault_o      (fault_w),
    .fire_o       (fire_w),
    .load_o       (load_w)
  );

  rtc_shadow_store #(
    .CNT_W (CNT_W),
    .P_W   (P_W),
    .Q_W   (Q_W),
    .ADDR_W(ADDR_W)
  ) store_i (
    .clk       (clk),
    .rst       (rst),
    .load_en   (load_w),
    .hold      (hold_w),
    .field_wr  (field_wr),
    .field_idx (field_idx),
    .wdata     (wdata),
    .live_cnt  (live_cnt),
    .live_p    (live_p),
    .live_q    (live_q),
    .shadow_vec(shadow_vec)
  );

  always_comb begin
    ctrl_byte                 = '0;
    ctrl_byte[CTRL_HOLD_BIT]  = busy_w;
    ctrl_byte[CTRL_FRZ_BIT]   = frz_w;
    ctrl_byte[CTRL_FAULT_BIT] = fault_w;
  end

  rtc_shadow_rdmux #(
    .ADDR_W(ADDR_W),
    .NBYTES(NBYTES)
  ) rdmux_i (
    .clk       (clk),
    .rst       (rst),
    .rd_en     (rd_en),
    .addr      (addr),
    .ctrl_byte (ctrl_byte),
    .shadow_vec(shadow_vec),
    .rdata     (rdata)
  );

  logic             commit_q;
  logic [CNT_W-1:0] commit_cnt_q;
  logic [P_W-1:0]   commit_p_q;
  logic [Q_W-1:0]   commit_qw_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      commit_q     <= 1'b0;
      commit_cnt_q <= '0;
      commit_p_q   <= '0;
      commit_qw_q  <= '0;
    end else begin
      commit_q <= fire_w;
      if (fire_w) begin
        commit_cnt_q <= shadow_vec[0 +: CNT_W];
        commit_p_q   <= shadow_vec[P_OFF +: P_W];
        commit_qw_q  <= shadow_vec[Q_OFF +: Q_W];
      end
    end
  end

  assign commit_o     = commit_q;
  assign commit_cnt_o = commit_cnt_q;
  assign commit_p_o   = commit_p_q;
  assign commit_q_o   = commit_qw_q;
  assign rd_frozen_o  = frz_w;
  assign wr_busy_o    = busy_w;
  assign fault_o      = fault_w;
endmodule

// File: rtl/rtc_shadow_chk.sv
module rtc_shadow_chk #(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 4,
  parameter int FV_W   = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        wdata,
  input logic              rtc_tick,
  input logic              cnt_err,
  input logic              commit_o,
  input logic [CNT_W-1:0]  commit_cnt_o,
  input logic              rd_frozen_o,
  input logic              wr_busy_o,
  input logic              fault_o,
  input logic              hold_w,
  input logic [FV_W-1:0]   shadow_vec
);
  p_commit_one_cycle_r10: assert property (@(posedge clk) disable iff (rst)
    commit_o |=> !commit_o);

  p_commit_after_tick_r7: assert property (@(posedge clk) disable iff (rst)
    commit_o |-> ($past(rtc_tick) && $past(wr_busy_o)));

  p_commit_value_r7: assert property (@(posedge clk) disable iff (rst)
    commit_o |-> (commit_cnt_o == $past(shadow_vec[CNT_W-1:0])));

  p_busy_drop_with_commit_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(wr_busy_o) |-> commit_o);

  p_err_sets_fault_r9: assert property (@(posedge clk) disable iff (rst)
    cnt_err |=> fault_o);

  p_fault_clear_by_write_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(fault_o) |-> $past(wr_en && (addr == '0) && !wdata[4]));

  p_frozen_shadow_r2: assert property (@(posedge clk) disable iff (rst)
    (rd_frozen_o && !wr_en) |=> $stable(shadow_vec));

  p_idle_shadow_r4: assert property (@(posedge clk) disable iff (rst)
    (!rtc_tick && !wr_en) |=> $stable(shadow_vec));

  p_ignored_write_r6: assert property (@(posedge clk) disable iff (rst)
    (!hold_w && !rtc_tick) |=> $stable(shadow_vec));
endmodule

bind rtc_shadow_ctrl rtc_shadow_chk #(
  .CNT_W (CNT_W),
  .ADDR_W(ADDR_W),
  .FV_W  (FV_W)
) chk_i (
  .clk         (clk),
  .rst         (rst),
  .wr_en       (wr_en),
  .addr        (addr),
  .wdata       (wdata),
  .rtc_tick    (rtc_tick),
  .cnt_err     (cnt_err),
  .commit_o    (commit_o),
  .commit_cnt_o(commit_cnt_o),
  .rd_frozen_o (rd_frozen_o),
  .wr_busy_o   (wr_busy_o),
  .fault_o     (fault_o),
  .hold_w      (hold_w),
  .shadow_vec  (shadow_vec)
);

// File: tb/rtc_shadow_ctrl_tb_top.sv
`timescale 1ns/1ps
module rtc_shadow_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [31:0] live_cnt = '0;
  logic [16:0] live_p = '0;
  logic [1:0]  live_q = '0;
  logic        rtc_tick = 1'b0, cnt_err = 1'b0;
  logic        commit_o;
  logic [31:0] commit_cnt_o;
  logic [16:0] commit_p_o;
  logic [1:0]  commit_q_o;
  logic        rd_frozen_o, wr_busy_o, fault_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #4 clk = ~clk;

  rtc_shadow_ctrl dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .live_cnt(live_cnt), .live_p(live_p),
    .live_q(live_q), .rtc_tick(rtc_tick), .cnt_err(cnt_err),
    .commit_o(commit_o), .commit_cnt_o(commit_cnt_o), .commit_p_o(commit_p_o),
    .commit_q_o(commit_q_o), .rd_frozen_o(rd_frozen_o), .wr_busy_o(wr_busy_o),
    .fault_o(fault_o)
  );

  // bench shadow model
  logic [31:0] sh_cnt = '0;
  logic [16:0] sh_p = '0;
  logic [1:0]  sh_q = '0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(input int a);
    logic [63:0] v;
    v = {6'b0, sh_q, 7'b0, sh_p, sh_cnt};
    if (a >= 1 && a <= 8) return v[(a-1)*8 +: 8];
    return 8'h00;
  endfunction

  function automatic logic [7:0] lane_msk(input int a);
    if (a == 7) return 8'h01;
    if (a == 8) return 8'h03;
    return 8'hFF;
  endfunction

  task automatic bus_write(input int a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = 4'(a); wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_read(input int a, output logic [7:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = 4'(a);
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic do_tick(output logic seen);
    @(negedge clk);
    rtc_tick = 1'b1;
    @(negedge clk);
    rtc_tick = 1'b0;
    seen = commit_o;
  endtask

  task automatic read_all(input string req);
    logic [7:0] d;
    for (int a = 1; a <= 8; a++) begin
      bus_read(a, d);
      chk(req, {56'b0, d}, {56'b0, exp_byte(a)});
    end
  endtask

  task automatic read_ctrl(input string req, input logic [7:0] exp);
    logic [7:0] d;
    bus_read(0, d);
    chk(req, {56'b0, d}, {56'b0, exp});
    chk(req, {61'b0, wr_busy_o, rd_frozen_o, fault_o}, {61'b0, exp[7], exp[6], exp[4]});
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic       seen;
    logic [7:0] d;
    logic       m_hold, m_frz, m_pend, m_fault;
    logic [7:0] v;

    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    @(negedge clk);
    chk("R1 outputs", {60'b0, commit_o, rd_frozen_o, wr_busy_o, fault_o}, 64'd0);
    chk("R1 rdata", {56'b0, rdata}, 64'd0);
    chk("R1 commit values", {13'b0, commit_q_o, commit_p_o, commit_cnt_o}, 64'd0);
    for (int a = 0; a < 16; a++) begin
      bus_read(a, d);
      chk("R1 read", {56'b0, d}, 64'd0);
    end

    // R4: tracking across many live patterns
    for (int k = 0; k < 16; k++) begin
      live_cnt = 32'h1357_9BDF * 32'(k + 1) ^ 32'(k << 20);
      live_p   = 17'(32'h0001_2345 * (k + 3));
      live_q   = 2'(k);
      do_tick(seen);
      chk("R10 no commit when idle", {63'b0, seen}, 64'd0);
      sh_cnt = live_cnt; sh_p = live_p; sh_q = live_q;
      read_all("R4 tracking");
    end

    // R4: no reload without a tick
    live_cnt = 32'hDEAD_BEEF; live_p = 17'h1_FFFF; live_q = 2'd3;
    read_all("R4 hold between ticks");

    // R11: rdata holds when rd_en is low
    bus_read(1, d);
    repeat (3) @(negedge clk);
    chk("R11 rdata holds", {56'b0, rdata}, {56'b0, exp_byte(1)});
    for (int a = 9; a < 16; a++) begin
      bus_read(a, d);
      chk("R11 unmapped read", {56'b0, d}, 64'd0);
    end

    // R2/R3: read freeze
    bus_write(0, 8'h40);
    read_ctrl("R3 freeze readback", 8'h40);
    do_tick(seen);
    read_all("R2 frozen shadow");
    bus_write(0, 8'h00);
    read_ctrl("R3 freeze cleared", 8'h00);
    read_all("R2 no reload before tick");
    do_tick(seen);
    sh_cnt = live_cnt; sh_p = live_p; sh_q = live_q;
    read_all("R2 reload after unfreeze");

    // R6: field writes ignored while hold is 0
    for (int a = 1; a <= 8; a++) bus_write(a, 8'hA5);
    read_all("R6 ignored writes");

    // R5: hold opens fields, blocks ticks
    bus_write(0, 8'h80);
    read_ctrl("R3 hold readback", 8'h80);
    live_cnt = 32'h0BAD_F00D;
    do_tick(seen);
    chk("R5 no commit while held", {63'b0, seen}, 64'd0);
    read_all("R5 shadow blocked under hold");
    for (int a = 1; a <= 8; a++) begin
      bus_write(a, 8'(8'h3C + 8'(a * 29)));
    end
    begin
      logic [63:0] nv;
      nv = '0;
      for (int a = 1; a <= 8; a++) nv[(a-1)*8 +: 8] = 8'(8'h3C + 8'(a * 29)) & lane_msk(a);
      sh_cnt = nv[31:0]; sh_p = nv[48:32]; sh_q = nv[57:56];
    end
    read_all("R5 written bytes masked");

    // R7/R8/R10: release and commit on tick
    bus_write(0, 8'h00);
    read_ctrl("R8 busy while pending", 8'h80);
    repeat (5) @(negedge clk);
    chk("R7 no commit before tick", {63'b0, commit_o}, 64'd0);
    do_tick(seen);
    chk("R7 commit after tick", {63'b0, seen}, 64'd1);
    chk("R7 commit cnt", {32'b0, commit_cnt_o}, {32'b0, sh_cnt});
    chk("R7 commit p", {47'b0, commit_p_o}, {47'b0, sh_p});
    chk("R7 commit q", {62'b0, commit_q_o}, {62'b0, sh_q});
    chk("R8 busy drops with commit", {63'b0, wr_busy_o}, 64'd0);
    @(negedge clk);
    chk("R10 one cycle", {63'b0, commit_o}, 64'd0);
    read_ctrl("R8 ctrl after commit", 8'h00);
    read_all("R7 shadow kept through commit");
    do_tick(seen);
    chk("R10 single commit", {63'b0, seen}, 64'd0);
    sh_cnt = live_cnt; sh_p = live_p; sh_q = live_q;
    read_all("R4 tracking resumes");

    // R7: hold re-set before tick defers commit
    bus_write(0, 8'h80);
    bus_write(0, 8'h00);
    bus_write(0, 8'h80);
    do_tick(seen);
    chk("R7 deferred by hold", {63'b0, seen}, 64'd0);
    bus_write(0, 8'h00);
    do_tick(seen);
    chk("R7 deferred commit fires", {63'b0, seen}, 64'd1);
    chk("R7 deferred commit cnt", {32'b0, commit_cnt_o}, {32'b0, sh_cnt});

    // R9: fault flag
    @(negedge clk); cnt_err = 1'b1;
    @(negedge clk); cnt_err = 1'b0;
    read_ctrl("R9 fault set", 8'h10);
    bus_write(0, 8'h10);
    read_ctrl("R9 write 1 keeps fault", 8'h10);
    bus_write(0, 8'h00);
    read_ctrl("R9 write 0 clears", 8'h00);
    bus_write(0, 8'h10);
    read_ctrl("R9 write 1 cannot set", 8'h00);
    @(negedge clk);
    wr_en = 1'b1; addr = 4'd0; wdata = 8'h00; cnt_err = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; cnt_err = 1'b0;
    read_ctrl("R9 error beats clear", 8'h10);

    // R3/R8/R9: sweep every control write value
    m_hold = 0; m_frz = 0; m_pend = 0; m_fault = 1;
    for (int i = 0; i < 256; i++) begin
      v = 8'(i * 37 + 11);
      bus_write(0, v);
      if (m_hold && !v[7]) m_pend = 1;
      m_hold = v[7]; m_frz = v[6];
      if (!v[4]) m_fault = 0;
      read_ctrl("R3 sweep", {m_hold | m_pend, m_frz, 1'b0, m_fault, 4'b0});
    end
    bus_write(0, 8'h00);
    if (m_hold) m_pend = 1;
    do_tick(seen);
    chk("R7 commit after sweep", {63'b0, seen}, {63'b0, m_pend});
    read_ctrl("R8 idle after sweep", 8'h00);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule